// File: doc/BRIEF.md
# Read Burst Strobe Sequencer

This block is the memory-side sequencer that answers a read command with a timed double-rate burst and a strobe it drives itself. A command carries a bank, a column and a burst-length select, and it is sampled together with a CAS latency select. After that latency the block presents two beat slots per clock, a rise slot and a fall slot. Each slot carries a strobe level, a data word and a valid flag.

Before each burst the strobe drops from its HIGH rest level for one preamble cycle. After the last falling strobe edge it stays LOW for one postamble cycle and is then released HIGH. Data words are computed from the bank and the beat's column. When a new burst's data follows directly on the previous one, the preamble and postamble are left out and the strobe toggles without a break.

Top module: `rd_burst_seq`

## Requirements
- R1: During and after reset, and whenever no burst, preamble or postamble is due, both strobe slots are HIGH, both data slots are all ones and both valid flags are low. In every cycle that is not a data cycle, both data slots are all ones.
- R2: A command sampled with `rd_valid` at a rising edge produces its first data cycle in the clock period that starts CL rising edges later, where CL = 7 + `cas_sel` (select 0, 1, 2, 3 gives 7, 8, 9, 10).
- R3: `rd_bl8` = 0 gives 4 beats, which is 2 data cycles. `rd_bl8` = 1 gives 8 beats, which is 4 data cycles. Within a cycle the rise slot holds the earlier beat.
- R4: In a data cycle the rise strobe slot is HIGH, the fall strobe slot is LOW and both valid flags are high, so each data beat sits on one strobe edge.
- R5: A data cycle whose previous cycle was not a data cycle is preceded by one cycle with both strobe slots LOW (preamble).
- R6: A data cycle followed by a non-data cycle is followed by one cycle with both strobe slots LOW (postamble). The strobe then returns HIGH unless a preamble or burst is due.
- R7: The two least significant bits of `rd_col` are ignored. The beats of a burst use consecutive columns starting at the command column with those bits cleared, wrapping modulo 2^COL_W.
- R8: A beat's data word carries the column in bits [COL_W-1:0] and the bank in bits [COL_W+BANK_W-1:COL_W]. All other bits are zero.
- R9: A command sampled exactly one burst length in cycles after the previous one gives data cycles without a gap and with no preamble or postamble between them. For 4-beat bursts this means one idle cycle between the commands.
- R10: A started burst always runs to completion. A command whose first data cycle would fall inside a running burst is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | Read command strobe, one cycle per command |
| rd_bank | input | BANK_W | Bank of the read |
| rd_col | input | COL_W | Start column; two low bits ignored |
| rd_bl8 | input | 1 | 1 selects 8 beats, 0 selects 4 beats |
| cas_sel | input | CLS_W | Latency select, CL = CL_MIN + cas_sel |
| dq_rise | output | DW | Data word of the rise slot |
| dq_fall | output | DW | Data word of the fall slot |
| dqs_rise | output | 1 | Strobe level in the rise slot |
| dqs_fall | output | 1 | Strobe level in the fall slot |
| vld_rise | output | 1 | Rise slot carries a data beat |
| vld_fall | output | 1 | Fall slot carries a data beat |

## Verification
A command sampled at the edge that starts bench cycle K owes its first data cycle at cycle K+CL, its preamble at K+CL-1 and its postamble in the first cycle after its last data cycle. The bench keeps its own cycle count. At each command it schedules the data cycles of that command in that count, and it drops a command whose first slot is already taken. Every cycle, the bench derives the expected preamble, postamble or idle levels from the neighbouring scheduled cycles. All outputs are compared at the falling edge, half a period after the register update they belong to.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    // Kind of clock period the sequencer is driving
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2,
        PH_POST = 2'd3
    } phase_e;

endpackage

// File: rtl/rbs_lat_pipe.sv
module rbs_lat_pipe #(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int CL_MIN = 7,
    parameter int CLS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_bl8,
    input  logic [CLS_W-1:0]  cmd_cls,
    output logic              head_valid,
    output logic [BANK_W-1:0] head_bank,
    output logic [COL_W-1:0]  head_col,
    output logic              head_bl8,
    output logic              next_valid
);

    localparam int CL_MAX = CL_MIN + (1 << CLS_W) - 1;
    localparam int DEPTH  = CL_MAX;
    localparam int IDX_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              vld;
        logic              bl8;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } tok_t;

    tok_t slot_q [DEPTH];
    tok_t slot_d [DEPTH];
    tok_t upper  [DEPTH];
    logic [IDX_W-1:0] ins_idx;

    // Each slot takes the content of the slot above it; the top one empties
    for (genvar g = 0; g < DEPTH; g++) begin : g_shift
        if (g == DEPTH - 1) begin : g_top
            assign upper[g] = '0;
        end else begin : g_mid
            assign upper[g] = slot_q[g+1];
        end
    end

    // A token placed at index CL-1 reaches the head after CL-1 edges;
    // the engine register adds the last cycle of latency.
    always_comb begin
        ins_idx = IDX_W'(CL_MIN - 1) + IDX_W'(cmd_cls);
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = upper[i];
            if (cmd_valid && ins_idx == IDX_W'(i)) begin
                slot_d[i].vld  = 1'b1;
                slot_d[i].bl8  = cmd_bl8;
                slot_d[i].bank = cmd_bank;
                slot_d[i].col  = cmd_col & ~COL_W'(3);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign head_valid = slot_q[0].vld;
    assign head_bank  = slot_q[0].bank;
    assign head_col   = slot_q[0].col;
    assign head_bl8   = slot_q[0].bl8;
    assign next_valid = slot_q[1].vld;

endmodule

// File: rtl/rbs_burst_engine.sv
module rbs_burst_engine
    import rbs_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int BL_SHORT = 4,
    parameter int BL_LONG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [BANK_W-1:0] head_bank,
    input  logic [COL_W-1:0]  head_col,
    input  logic              head_bl8,
    input  logic              next_valid,
    output logic [DW-1:0]     dq_rise,
    output logic [DW-1:0]     dq_fall,
    output logic              dqs_rise,
    output logic              dqs_fall,
    output logic              vld_rise,
    output logic              vld_fall
);

    localparam int CYC_SHORT = BL_SHORT / 2;
    localparam int CYC_LONG  = BL_LONG / 2;
    localparam int CYC_W     = $clog2(CYC_LONG + 1);

    typedef struct packed {
        logic              busy;
        logic [CYC_W-1:0]  left;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [DW-1:0]     dq_r;
        logic [DW-1:0]     dq_f;
        logic              s_r;
        logic              s_f;
        logic              v_r;
        logic              v_f;
    } st_t;

    st_t    st_q, st_d;
    phase_e phase;

    function automatic logic [DW-1:0] beat_word(input logic [BANK_W-1:0] b,
                                                input logic [COL_W-1:0]  c);
        logic [DW-1:0] w;
        w = '0;
        w[BANK_W+COL_W-1:0] = {b, c};
        return w;
    endfunction

    always_comb begin
        st_d  = st_q;
        phase = PH_IDLE;
        // Priority: running burst, new burst, postamble, preamble, rest
        if (st_q.busy && st_q.left > CYC_W'(1)) begin
            phase     = PH_DATA;
            st_d.left = st_q.left - CYC_W'(1);
            st_d.col  = st_q.col + COL_W'(2);
        end else if (head_valid) begin
            phase     = PH_DATA;
            st_d.busy = 1'b1;
            st_d.left = head_bl8 ? CYC_W'(CYC_LONG) : CYC_W'(CYC_SHORT);
            st_d.bank = head_bank;
            st_d.col  = head_col;
        end else if (st_q.busy) begin
            phase     = PH_POST;
            st_d.busy = 1'b0;
            st_d.left = '0;
        end else if (next_valid) begin
            phase = PH_PRE;
        end

        unique case (phase)
            PH_DATA: begin
                st_d.dq_r = beat_word(st_d.bank, st_d.col);
                st_d.dq_f = beat_word(st_d.bank, st_d.col + COL_W'(1));
                st_d.s_r  = 1'b1;
                st_d.s_f  = 1'b0;
                st_d.v_r  = 1'b1;
                st_d.v_f  = 1'b1;
            end
            PH_PRE, PH_POST: begin
                st_d.dq_r = '1;
                st_d.dq_f = '1;
                st_d.s_r  = 1'b0;
                st_d.s_f  = 1'b0;
                st_d.v_r  = 1'b0;
                st_d.v_f  = 1'b0;
            end
            default: begin
                st_d.dq_r = '1;
                st_d.dq_f = '1;
                st_d.s_r  = 1'b1;
                st_d.s_f  = 1'b1;
                st_d.v_r  = 1'b0;
                st_d.v_f  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dq_r <= '1;
            st_q.dq_f <= '1;
            st_q.s_r  <= 1'b1;
            st_q.s_f  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_rise  = st_q.dq_r;
    assign dq_fall  = st_q.dq_f;
    assign dqs_rise = st_q.s_r;
    assign dqs_fall = st_q.s_f;
    assign vld_rise = st_q.v_r;
    assign vld_fall = st_q.v_f;

    // R7
    head_col_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |-> (head_col[1:0] == 2'b00));

endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq #(
    parameter int DW     = 32,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int CL_MIN = 7,
    parameter int CLS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              rd_bl8,
    input  logic [CLS_W-1:0]  cas_sel,
    output logic [DW-1:0]     dq_rise,
    output logic [DW-1:0]     dq_fall,
    output logic              dqs_rise,
    output logic              dqs_fall,
    output logic              vld_rise,
    output logic              vld_fall
);

    logic              head_valid;
    logic [BANK_W-1:0] head_bank;
    logic [COL_W-1:0]  head_col;
    logic              head_bl8;
    logic              next_valid;

    rbs_lat_pipe #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .CL_MIN (CL_MIN),
        .CLS_W  (CLS_W)
    ) lat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (rd_valid),
        .cmd_bank   (rd_bank),
        .cmd_col    (rd_col),
        .cmd_bl8    (rd_bl8),
        .cmd_cls    (cas_sel),
        .head_valid (head_valid),
        .head_bank  (head_bank),
        .head_col   (head_col),
        .head_bl8   (head_bl8),
        .next_valid (next_valid)
    );

    rbs_burst_engine #(
        .DW       (DW),
        .BANK_W   (BANK_W),
        .COL_W    (COL_W),
        .BL_SHORT (4),
        .BL_LONG  (8)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_bank  (head_bank),
        .head_col   (head_col),
        .head_bl8   (head_bl8),
        .next_valid (next_valid),
        .dq_rise    (dq_rise),
        .dq_fall    (dq_fall),
        .dqs_rise   (dqs_rise),
        .dqs_fall   (dqs_fall),
        .vld_rise   (vld_rise),
        .vld_fall   (vld_fall)
    );

    // R4
    data_edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_rise |-> (vld_fall && dqs_rise && !dqs_fall));

    // R5
    preamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_rise && !$past(vld_rise)) |-> (!$past(dqs_rise) && !$past(dqs_fall)));

    // R6
    postamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_rise && $past(vld_rise)) |-> (!dqs_rise && !dqs_fall));

    // R1
    idle_data_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_rise |-> (!vld_fall && dq_rise == '1 && dq_fall == '1));

endmodule

// File: tb/rd_burst_seq_tb_top.sv
module rd_burst_seq_tb_top;

    localparam int DW     = 32;
    localparam int BANK_W = 3;
    localparam int COL_W  = 10;
    localparam int CL_MIN = 7;
    localparam int CLS_W  = 2;
    localparam int COL_MASK = (1 << COL_W) - 1;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_valid = 1'b0;
    logic [BANK_W-1:0] rd_bank = '0;
    logic [COL_W-1:0]  rd_col = '0;
    logic              rd_bl8 = 1'b0;
    logic [CLS_W-1:0]  cas_sel = '0;
    logic [DW-1:0]     dq_rise, dq_fall;
    logic              dqs_rise, dqs_fall, vld_rise, vld_fall;

    always #10 clk = ~clk;   // 50 MHz

    rd_burst_seq #(
        .DW(DW), .BANK_W(BANK_W), .COL_W(COL_W), .CL_MIN(CL_MIN), .CLS_W(CLS_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_bank(rd_bank),
        .rd_col(rd_col), .rd_bl8(rd_bl8), .cas_sel(cas_sel),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dqs_rise(dqs_rise),
        .dqs_fall(dqs_fall), .vld_rise(vld_rise), .vld_fall(vld_fall)
    );

    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference schedule: cycle number -> data cycle with bank and rise column
    bit dat_on   [int];
    int dat_bank [int];
    int dat_col  [int];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] ref_word(int b, int c);
        logic [DW-1:0] w;
        w = '0;
        w[COL_W-1:0] = COL_W'(c & COL_MASK);
        w[COL_W+BANK_W-1:COL_W] = BANK_W'(b);
        return w;
    endfunction

    // Command driven now is sampled at the next edge, i.e. cycle cyc+1
    task automatic issue(int bank, int col, bit bl8, int cls);
        int k;
        int first;
        int ncyc;
        int base;
        k     = cyc + 1;
        first = k + CL_MIN + cls;
        ncyc  = bl8 ? 4 : 2;
        base  = col & ~3;
        // R10: a burst already owning the first slot wins
        if (!dat_on.exists(first)) begin
            for (int i = 0; i < ncyc; i++) begin
                dat_on[first+i]   = 1'b1;
                dat_bank[first+i] = bank;
                dat_col[first+i]  = (base + 2*i) & COL_MASK;
            end
        end
        rd_valid = 1'b1;
        rd_bank  = BANK_W'(bank);
        rd_col   = COL_W'(col);
        rd_bl8   = bl8;
        cas_sel  = CLS_W'(cls);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare every cycle, half a period after the output register updates
    always @(negedge clk) begin
        if (!done) begin
            logic [DW-1:0] e_dr, e_df;
            logic e_sr, e_sf, e_v;
            string kind;
            int c;
            c = cyc;
            if (dat_on.exists(c)) begin
                kind = "R4 R8 data";
                e_dr = ref_word(dat_bank[c], dat_col[c]);
                e_df = ref_word(dat_bank[c], dat_col[c] + 1);
                e_sr = 1'b1; e_sf = 1'b0; e_v = 1'b1;
            end else if (dat_on.exists(c - 1)) begin
                kind = "R6 post";
                e_dr = '1; e_df = '1; e_sr = 1'b0; e_sf = 1'b0; e_v = 1'b0;
            end else if (dat_on.exists(c + 1)) begin
                kind = "R5 pre";
                e_dr = '1; e_df = '1; e_sr = 1'b0; e_sf = 1'b0; e_v = 1'b0;
            end else begin
                kind = "R1 idle";
                e_dr = '1; e_df = '1; e_sr = 1'b1; e_sf = 1'b1; e_v = 1'b0;
            end
            n_checks++;
            if (dq_rise !== e_dr || dq_fall !== e_df || dqs_rise !== e_sr ||
                dqs_fall !== e_sf || vld_rise !== e_v || vld_fall !== e_v) begin
                n_errors++;
                $display("FAIL %s (%s) cyc=%0d got dq=%h/%h dqs=%b%b vld=%b%b exp dq=%h/%h dqs=%b%b vld=%b%b",
                         cur_req, kind, c, dq_rise, dq_fall, dqs_rise, dqs_fall,
                         vld_rise, vld_fall, e_dr, e_df, e_sr, e_sf, e_v, e_v);
            end
        end
    end

    initial begin
        // R1: reset state and rest levels
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(6);

        // R2: every latency select, 4-beat bursts
        cur_req = "R2";
        for (int s = 0; s < 4; s++) begin
            issue(s, 16*s + 4, 1'b0, s);
            idle(20);
        end

        // R3: 8-beat and 4-beat lengths
        cur_req = "R3";
        issue(5, 'h40, 1'b1, 1);
        idle(20);
        issue(6, 'h80, 1'b0, 3);
        idle(20);

        // R7: low column bits ignored, column wrap at the top
        cur_req = "R7";
        issue(2, 'h2B, 1'b1, 0);
        idle(20);
        issue(7, 'h3FE, 1'b1, 2);
        idle(20);

        // R9: back-to-back streams
        cur_req = "R9";
        for (int i = 0; i < 4; i++) begin
            issue(i, 'h100 + 8*i + 1, 1'b0, 1);
            idle(1);
        end
        idle(20);
        for (int i = 0; i < 3; i++) begin
            issue(i + 3, 'h200 + 16*i, 1'b1, 2);
            idle(3);
        end
        idle(20);
        issue(1, 'h300, 1'b1, 0);
        idle(3);
        issue(4, 'h30C, 1'b0, 0);
        idle(20);

        // R6 and R5: one-cycle gap between bursts
        cur_req = "R6";
        issue(3, 'h50, 1'b0, 1);
        idle(2);
        issue(2, 'h60, 1'b0, 1);
        idle(20);

        // R10: overlapping command is discarded, running burst completes
        cur_req = "R10";
        issue(6, 'h120, 1'b1, 3);
        issue(1, 'h140, 1'b0, 3);
        idle(20);
        issue(5, 'h180, 1'b0, 0);
        issue(0, 'h1C0, 1'b1, 0);
        idle(20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run still busy, expected done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule